// File: doc/BRIEF.md
# Non-Overlapping Multiphase Pulse Output Unit

This block drives an 8-bit pulse port (two 4-bit groups) from a pattern that the host keeps loading into a staging register. An internal counter runs from zero up to a period limit and wraps. Each wrap is a *period event*. A second, smaller limit marks a *margin event* inside each period.

A group in non-overlap mode splits each pattern change across the two events. Bits that fall from 1 to 0 fall at the period event. Bits that rise from 0 to 1 rise only at the margin event. As a result, complementary phases are never high together. A group in plain mode takes the whole staged pattern at the period event.

The margin event sets a sticky request flag. When enabled, this flag raises the interrupt, and the host's handler stages the next pattern. Loading 0x95, 0x65, 0x59, 0x56, 0x95 in turn produces a four-phase complementary sequence.

The host side is a plain register write strobe with no back-pressure: a write is taken on every clock edge where `wr_en` is high. The pulse port and the interrupt are plain level outputs with no handshake, because the pattern advances on the block's own timebase.

Top module: `npo_unit`

## Requirements
- R1: While the run bit (control bit 0) is 1, the counter counts up from 0 and returns to 0 on the edge after it equals the period register (address 1), so period events are PERIOD+1 cycles apart. While the run bit is 0, the counter is held at 0 and no event occurs.
- R2: At a period event, a group whose non-overlap bit is 1 (control bit 2 for bits 3:0, control bit 3 for bits 7:4) loads its old output ANDed with the staged pattern. Only falls happen here.
- R3: At a margin event (the counter equals the margin register, address 2, and margin < period), a non-overlap group loads the full staged pattern.
- R4: A group whose non-overlap bit is 0 loads the staged pattern at the period event, and the margin event leaves it unchanged.
- R5: A margin event sets the request flag. `irq` equals the flag ANDed with the interrupt enable (control bit 1). Writing 1 to bit 0 of address 5 clears the flag, except when a margin event happens in the same cycle; then the flag stays set.
- R6: If the margin is greater than or equal to the period, no margin event occurs. The rising-edge update and the flag setting are skipped.
- R7: Pin k drives its output bit only when its direction bit (address 4, bit k) and its enable bit (address 4, bit 8+k) are both 1. Otherwise the pin reads 0. `pin_oe` shows the AND of the two bits.
- R8: The staging register (address 0, bits 7:0) may be written at any time. An event takes the value held before that edge, so a write made in the same cycle as the event applies to later events only.
- R9: With both groups in non-overlap mode and the pattern sequence 0x95, 0x65, 0x59, 0x56, 0x95, the port shows 0x05, 0x41, 0x50 and 0x14 between each period event and the following margin event.
- R10: After reset, all registers, the counter, the outputs and the flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Write data |
| pulse_out | output | 8 | Pulse port value |
| pin_oe | output | 8 | Per-pin drive enable |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker enforces the following on every cycle:
- the counter returns to 0 after a period event;
- a non-overlap group never gains a 1 at a period event;
- a plain group holds still at a margin event;
- the flag sets after a margin event and clears after an uncontested clear write.

Several behaviours can only be shown by the bench's scenarios against its reference model:
- the exact output values;
- the four-phase intermediate patterns;
- the ordering when a staging write lands on an event cycle;
- the suppressed margin when the margin is not below the period;
- the per-pin drive gating.

// File: rtl/npo_pkg.sv
package npo_pkg;
  localparam logic [2:0] ADDR_NEXT   = 3'd0;
  localparam logic [2:0] ADDR_PERIOD = 3'd1;
  localparam logic [2:0] ADDR_MARGIN = 3'd2;
  localparam logic [2:0] ADDR_CTRL   = 3'd3;
  localparam logic [2:0] ADDR_PINEN  = 3'd4;
  localparam logic [2:0] ADDR_STAT   = 3'd5;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_IE   = 1;
  localparam int CTRL_NOV0 = 2;
endpackage

// File: rtl/npo_regs.sv
module npo_regs
  import npo_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PORT_W = 8,
  parameter int N_GRP  = 2,
  parameter int WR_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [WR_W-1:0]   wr_data,
  input  logic              set_flag,
  output logic [PORT_W-1:0] next_q,
  output logic [CNT_W-1:0]  period_q,
  output logic [CNT_W-1:0]  margin_q,
  output logic              run,
  output logic              ie,
  output logic [N_GRP-1:0]  nov,
  output logic [PORT_W-1:0] dir_q,
  output logic [PORT_W-1:0] nde_q,
  output logic              flag_q
);
  localparam int CTRL_W = CTRL_NOV0 + N_GRP;

  logic [CTRL_W-1:0] ctrl_q;

  assign run = ctrl_q[CTRL_RUN];
  assign ie  = ctrl_q[CTRL_IE];
  assign nov = ctrl_q[CTRL_NOV0 +: N_GRP];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_q   <= '0;
      period_q <= '0;
      margin_q <= '0;
      ctrl_q   <= '0;
      dir_q    <= '0;
      nde_q    <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        ADDR_NEXT:   next_q   <= wr_data[PORT_W-1:0];
        ADDR_PERIOD: period_q <= wr_data[CNT_W-1:0];
        ADDR_MARGIN: margin_q <= wr_data[CNT_W-1:0];
        ADDR_CTRL:   ctrl_q   <= wr_data[CTRL_W-1:0];
        ADDR_PINEN: begin
          dir_q <= wr_data[PORT_W-1:0];
          nde_q <= wr_data[2*PORT_W-1:PORT_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (set_flag)
      flag_q <= 1'b1;
    else if (wr_en && wr_addr == ADDR_STAT && wr_data[0])
      flag_q <= 1'b0;
  end
endmodule

// File: rtl/npo_timer.sv
module npo_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] margin,
  output logic [CNT_W-1:0] cnt_q,
  output logic             match_p,
  output logic             match_m
);
  assign match_p = run && (cnt_q == period);
  assign match_m = run && (cnt_q == margin) && (margin < period);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || match_p)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/npo_outgrp.sv
module npo_outgrp #(
  parameter int GRP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nov,
  input  logic             match_p,
  input  logic             match_m,
  input  logic [GRP_W-1:0] staged,
  output logic [GRP_W-1:0] out_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      out_q <= '0;
    else if (match_p)
      out_q <= nov ? (out_q & staged) : staged;
    else if (match_m && nov)
      out_q <= staged;
  end
endmodule

// File: rtl/npo_unit.sv
module npo_unit #(
  parameter int CNT_W = 16,
  parameter int GRP_W = 4,
  parameter int N_GRP = 2,
  localparam int PORT_W = GRP_W * N_GRP,
  localparam int WR_W   = (CNT_W > 2 * PORT_W) ? CNT_W : 2 * PORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [WR_W-1:0]   wr_data,
  output logic [PORT_W-1:0] pulse_out,
  output logic [PORT_W-1:0] pin_oe,
  output logic              irq
);
  logic [PORT_W-1:0] next_q, dir_q, nde_q, out_q;
  logic [CNT_W-1:0]  period_q, margin_q, cnt_q;
  logic              run, ie, flag, match_p, match_m;
  logic [N_GRP-1:0]  nov;

  npo_regs #(.CNT_W(CNT_W), .PORT_W(PORT_W), .N_GRP(N_GRP), .WR_W(WR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .set_flag(match_m), .next_q(next_q), .period_q(period_q), .margin_q(margin_q),
    .run(run), .ie(ie), .nov(nov), .dir_q(dir_q), .nde_q(nde_q), .flag_q(flag)
  );

  npo_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .period(period_q), .margin(margin_q),
    .cnt_q(cnt_q), .match_p(match_p), .match_m(match_m)
  );

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    npo_outgrp #(.GRP_W(GRP_W)) u_grp (
      .clk(clk), .rst_n(rst_n), .nov(nov[g]), .match_p(match_p), .match_m(match_m),
      .staged(next_q[g*GRP_W +: GRP_W]), .out_q(out_q[g*GRP_W +: GRP_W])
    );
  end

  assign pin_oe    = dir_q & nde_q;
  assign pulse_out = out_q & pin_oe;
  assign irq       = flag & ie;
endmodule

// File: rtl/npo_unit_chk.sv
module npo_unit_chk
  import npo_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int GRP_W  = 4,
  parameter int N_GRP  = 2,
  parameter int WR_W   = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     match_p,
  input logic                     match_m,
  input logic [N_GRP-1:0]         nov,
  input logic [GRP_W*N_GRP-1:0]   out_q,
  input logic                     flag,
  input logic [CNT_W-1:0]         cnt_q,
  input logic                     wr_en,
  input logic [2:0]               wr_addr,
  input logic [WR_W-1:0]          wr_data
);
  a_r1_wrap_after_period: assert property (@(posedge clk) disable iff (!rst_n)
    match_p |=> (cnt_q == '0));

  a_r5_margin_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    match_m |=> flag);

  a_r5_clear_when_uncontested: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !match_m && wr_en && wr_addr == ADDR_STAT && wr_data[0]) |=> !flag);

  for (genvar g = 0; g < N_GRP; g++) begin : g_chk
    a_r2_no_rise_at_period: assert property (@(posedge clk) disable iff (!rst_n)
      (match_p && nov[g]) |=>
        ((out_q[g*GRP_W +: GRP_W] & ~$past(out_q[g*GRP_W +: GRP_W])) == '0));

    a_r4_plain_holds_at_margin: assert property (@(posedge clk) disable iff (!rst_n)
      (match_m && !nov[g]) |=> $stable(out_q[g*GRP_W +: GRP_W]));
  end
endmodule

bind npo_unit npo_unit_chk #(.CNT_W(CNT_W), .GRP_W(GRP_W), .N_GRP(N_GRP), .WR_W(WR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .match_p(match_p), .match_m(match_m), .nov(nov),
  .out_q(out_q), .flag(flag), .cnt_q(cnt_q), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data)
);

// File: tb/tb_npo_unit.sv
module tb_npo_unit;
  localparam logic [2:0] A_NEXT = 3'd0, A_PER = 3'd1, A_MAR = 3'd2,
                         A_CTRL = 3'd3, A_PIN = 3'd4, A_STAT = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  pulse_out, pin_oe;
  logic        irq;

  int nchk = 0;
  int nerr = 0;

  // reference model state
  logic [15:0] m_cnt, m_per, m_mar, m_pin;
  logic [7:0]  m_next, m_out;
  logic [3:0]  m_ctrl;
  logic        m_flag, last_pm, last_mm;

  always #2 clk = ~clk;

  npo_unit dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
                .wr_data(wr_data), .pulse_out(pulse_out), .pin_oe(pin_oe), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] grp_next(logic [3:0] cur, logic [3:0] stg,
                                          logic nov, logic pm, logic mm);
    if (pm) return nov ? (cur & stg) : stg;
    if (mm && nov) return stg;
    return cur;
  endfunction

  task automatic model_reset();
    m_cnt = '0; m_per = '0; m_mar = '0; m_pin = '0;
    m_next = '0; m_out = '0; m_ctrl = '0; m_flag = 1'b0;
    last_pm = 1'b0; last_mm = 1'b0;
  endtask

  task automatic cyc();
    logic pm, mm;
    string lbl;
    @(posedge clk);
    pm = m_ctrl[0] && (m_cnt == m_per);
    mm = m_ctrl[0] && (m_cnt == m_mar) && (m_mar < m_per);
    m_out[3:0] = grp_next(m_out[3:0], m_next[3:0], m_ctrl[2], pm, mm);
    m_out[7:4] = grp_next(m_out[7:4], m_next[7:4], m_ctrl[3], pm, mm);
    if (mm) m_flag = 1'b1;
    else if (wr_en && wr_addr == A_STAT && wr_data[0]) m_flag = 1'b0;
    m_cnt = (!m_ctrl[0] || pm) ? 16'd0 : m_cnt + 16'd1;
    if (wr_en) begin
      case (wr_addr)
        A_NEXT: m_next = wr_data[7:0];
        A_PER:  m_per  = wr_data;
        A_MAR:  m_mar  = wr_data;
        A_CTRL: m_ctrl = wr_data[3:0];
        A_PIN:  m_pin  = wr_data;
        default: ;
      endcase
    end
    last_pm = pm; last_mm = mm;
    @(negedge clk);
    if (pm) lbl = (m_ctrl[3:2] != 2'b00) ? "R2 R1 R8" : "R4 R1 R8";
    else if (mm) lbl = "R3 R4";
    else if (m_ctrl[0] && m_mar >= m_per) lbl = "R6";
    else lbl = "R7";
    chk(lbl, pulse_out, m_out & m_pin[7:0] & m_pin[15:8]);
    chk("R7", pin_oe, m_pin[7:0] & m_pin[15:8]);
    chk("R5", irq, m_flag & m_ctrl[1]);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
  endtask

  task automatic setup(logic [15:0] per, logic [15:0] mar, logic [3:0] ctrl,
                       logic [15:0] pin, logic [7:0] nxt);
    wr(A_CTRL, 16'd0);
    wr(A_PER, per);
    wr(A_MAR, mar);
    wr(A_PIN, pin);
    wr(A_NEXT, {8'd0, nxt});
    wr(A_CTRL, {12'd0, ctrl});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] seq [5];
    logic [7:0] win [4];
    logic [7:0] full [4];
    logic [7:0] held;
    int idx;
    seq = '{8'h95, 8'h65, 8'h59, 8'h56, 8'h95};
    win = '{8'h05, 8'h41, 8'h50, 8'h14};
    full = '{8'h65, 8'h59, 8'h56, 8'h95};
    void'($urandom(32'd20240611));
    do_reset();
    @(negedge clk);
    chk("R10 reset pulse_out", pulse_out, 8'h00);
    chk("R10 reset pin_oe", pin_oe, 8'h00);
    chk("R10 reset irq", irq, 1'b0);

    // R9 four-phase complementary sequence
    setup(16'd20, 16'd5, 4'b1111, 16'hFFFF, 8'h95);
    idx = 1;
    while (idx < 5) begin
      cyc();
      if (last_pm && idx >= 2) chk("R9 margin window", pulse_out, win[idx-2]);
      if (last_mm && idx >= 2) chk("R9 after margin", pulse_out, full[idx-2]);
      if (irq) begin
        wr(A_NEXT, {8'd0, seq[idx]});
        wr(A_STAT, 16'd1);
        idx++;
      end
    end
    repeat (25) begin
      cyc();
      if (last_pm) chk("R9 margin window", pulse_out, win[3]);
    end

    // R8 staging write on the very cycle of a period event (plain mode)
    setup(16'd4, 16'd1, 4'b0001, 16'hFFFF, 8'h3C);
    while (m_cnt != 16'd4) cyc();
    cyc();
    held = pulse_out;
    while (m_cnt != 16'd4) cyc();
    wr(A_NEXT, 16'h00C3);
    chk("R8 event uses pre-write value", pulse_out, 8'h3C);
    while (m_cnt != 16'd4) cyc();
    cyc();
    chk("R8 later event uses new value", pulse_out, 8'hC3);
    chk("R4 first event", held, 8'h3C);

    // R6 margin not below period
    do_reset();
    setup(16'd6, 16'd6, 4'b1111, 16'hFFFF, 8'hFF);
    repeat (30) cyc();
    chk("R6 no flag", irq, 1'b0);
    chk("R6 no rise", pulse_out, 8'h00);

    // R5 clear collides with margin event
    setup(16'd6, 16'd2, 4'b0111, 16'hFFFF, 8'h0F);
    while (m_cnt != 16'd2) cyc();
    wr(A_STAT, 16'd1);
    chk("R5 set wins over clear", irq, 1'b1);
    wr(A_STAT, 16'd1);
    chk("R5 clear", irq, 1'b0);

    // R1 run stop holds counter
    wr(A_CTRL, 16'd0);
    repeat (20) cyc();
    chk("R1 stopped no flag", irq, 1'b0);

    // random segments
    for (int blk = 0; blk < 12; blk++) begin
      logic [15:0] per;
      per = 16'($urandom_range(3, 12));
      setup(per, 16'($urandom_range(0, per + 2)), {2'($urandom), 1'($urandom), 1'b1},
            16'($urandom), 8'($urandom));
      for (int k = 0; k < 300; k++) begin
        int r;
        r = $urandom % 12;
        if (r < 2) wr(A_NEXT, 16'($urandom));
        else if (r == 2) wr(A_STAT, 16'($urandom));
        else if (r == 3) wr(A_PIN, 16'($urandom));
        else if (r == 4) wr(A_CTRL, {12'd0, 2'($urandom), 1'($urandom), 1'b1});
        else cyc();
      end
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule